// File: doc/BRIEF.md
# Control-Flow Integrity Monitor

This block sits beside a processor's retirement stage and watches every retired instruction. It enforces two rules on the program's control flow.

The first rule uses a private return-address stack. Every call pushes the address it will return to. Every return compares its actual target with the newest entry. The stack lives only inside this block: its sole port is the event stream, so ordinary loads and stores cannot reach it.

The second rule covers indirect jumps and indirect calls. After one of these, the next retired instruction must carry the landing-marker flag. When a rule is broken, the block raises a one-cycle fault pulse with a 2-bit cause code. It then freezes until software clears it.

A small controller runs the checks. Its state machine has three states:

- `ST_MONITOR`: checking, with no landing marker pending.
- `ST_ARMED`: checking, and the next retired instruction must be a landing marker.
- `ST_HALTED`: a fault has fired, and events are ignored.

The transitions between them are:

- *arm*: an indirect branch is accepted, from `ST_MONITOR` or `ST_ARMED`, and the machine goes to `ST_ARMED`.
- *settle*: a non-indirect event is accepted, and the machine goes to `ST_MONITOR`.
- *trip*: a fault is detected, and the machine goes to `ST_HALTED`.
- *clear*: the clear input is seen in any state, and the machine goes to `ST_MONITOR`.

Cycles with no valid event leave the state unchanged.

Top module: `cfi_monitor`

## Requirements
- R1: Event class codes on `ev_class_i` are 000 plain, 001 direct call, 010 indirect call, 011 return and 100 indirect jump. Codes 101 to 111 act as plain. Calls push `ev_addr_i`, and a return whose `ev_addr_i` equals the newest entry pops it without a fault, in last-in first-out order.
- R2: A return whose target differs from the newest entry of a non-empty stack raises `fault_o` with cause 01 in the cycle after the event.
- R3: After an accepted indirect call or indirect jump, the next valid event must have `ev_landing_i`=1. Otherwise `fault_o` rises with cause 10 in the cycle after that event.
- R4: The landing-marker flag never faults on its own, and a direct call never arms the landing check.
- R5: With the return check enabled, a return on an empty stack or a call on a full stack raises cause 11. The default depth is 32 entries.
- R6: `fault_o` is low after reset and lasts exactly one cycle. After a fault, all events are ignored and no further fault fires until `clear_i`.
- R7: `clear_i` (synchronous, taking priority over an event in the same cycle) empties the stack, disarms the landing check and resumes monitoring.
- R8: With `ret_chk_en_i`=0, no cause 01 or 11 fault fires. Calls still push (unless the stack is full), and returns still pop (unless it is empty), so the stack stays consistent when the check is re-enabled.
- R9: With `land_chk_en_i`=0, no cause 10 fault fires. Arming still tracks indirect branches.
- R10: When one event breaks several rules, the cause priority is 10 over 11 over 01.
- R11: Cycles with `ev_valid_i`=0 change nothing, and a pending landing check survives such bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the fault state, the stack and the landing check |
| ev_valid_i | input | 1 | A retired-instruction event is present |
| ev_class_i | input | 3 | Event class code |
| ev_addr_i | input | ADDR_W | Return address for calls, actual target for returns |
| ev_landing_i | input | 1 | The retired instruction is a landing marker |
| ret_chk_en_i | input | 1 | Return-address check enable |
| land_chk_en_i | input | 1 | Landing-marker check enable |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause_o | output | 2 | Cause: 01 mismatch, 10 no landing, 11 stack bounds |

## Verification
The bench targets the stack boundaries:

- It fills the stack to exactly 32 entries and then issues one more call.
- It returns on an empty stack, including straight after a clear.

A design with an off-by-one full flag would overflow one entry early or late. A design whose clear left stale entries would pass a return that ought to underflow.

The bench also covers the landing check in three situations:

- It separates an indirect branch from its successor with bubbles. A design that disarms on idle cycles would miss the fault.
- It combines a missing marker with a stack-bound violation on the same event. A wrong priority would show the wrong cause.
- It sends mismatching returns while the return check is disabled. A design that skipped the pop would then report a bogus underflow or mismatch once the check is turned back on.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

    // Event class codes seen on the retirement interface
    typedef enum logic [2:0] {
        EV_PLAIN = 3'd0,
        EV_DCALL = 3'd1,
        EV_ICALL = 3'd2,
        EV_RET   = 3'd3,
        EV_IJMP  = 3'd4
    } ev_class_e;

    // Fault cause codes
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_MISMATCH = 2'b01,
        CAUSE_NO_LAND  = 2'b10,
        CAUSE_BOUNDS   = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HALTED  = 2'd2
    } mon_state_e;

    // Decoded view of one retired event
    typedef struct packed {
        logic push;
        logic pop;
        logic indirect;
        logic marker;
    } ev_dec_t;

endpackage

// File: rtl/cfi_event_decode.sv
module cfi_event_decode
    import cfi_pkg::*;
(
    input  logic [2:0] ev_class_i,
    input  logic       ev_landing_i,
    output ev_dec_t    dec_o
);

    always_comb begin
        dec_o        = '0;
        dec_o.marker = ev_landing_i;
        case (ev_class_e'(ev_class_i))
            EV_DCALL: dec_o.push = 1'b1;
            EV_ICALL: begin
                dec_o.push     = 1'b1;
                dec_o.indirect = 1'b1;
            end
            EV_RET:   dec_o.pop = 1'b1;
            EV_IJMP:  dec_o.indirect = 1'b1;
            default:  ; // plain instruction, including unused codes
        endcase
    end

endmodule

// File: rtl/cfi_shadow_stack.sv
module cfi_shadow_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              empty_o,
    output logic              full_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    logic [ADDR_W-1:0] slots [DEPTH];
    logic [CW-1:0]     fill;
    logic [CW-1:0]     top_idx;
    logic [CW-1:0]     wr_idx;

    assign top_idx = fill - CW'(1);
    assign wr_idx  = fill;
    assign top_o   = slots[top_idx[IW-1:0]];
    assign empty_o = (fill == '0);
    assign full_o  = (fill == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (flush_i) begin
            fill <= '0;
        end else if (push_i && !full_o) begin
            fill <= fill + CW'(1);
        end else if (pop_i && !empty_o) begin
            fill <= fill - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush_i && push_i && !full_o) begin
            slots[wr_idx[IW-1:0]] <= push_addr_i;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LIMIT);

    // R5
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/cfi_fault_ctrl.sv
module cfi_fault_ctrl
    import cfi_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ev_valid_i,
    input  ev_dec_t           dec_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic              ret_en_i,
    input  logic              land_en_i,
    input  logic [ADDR_W-1:0] stk_top_i,
    input  logic              stk_empty_i,
    input  logic              stk_full_i,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic              stk_flush_o,
    output logic              fault_o,
    output logic [1:0]        cause_o
);

    mon_state_e state, state_n;
    cause_e     cause_c;
    logic       active, land_miss, bounds, mism, trip, commit;

    assign active    = ev_valid_i && (state != ST_HALTED) && !clear_i;
    assign land_miss = (state == ST_ARMED) && !dec_i.marker && land_en_i;
    assign bounds    = ret_en_i && ((dec_i.push && stk_full_i) ||
                                    (dec_i.pop && stk_empty_i));
    assign mism      = ret_en_i && dec_i.pop && !stk_empty_i &&
                       (stk_top_i != ev_addr_i);

    always_comb begin
        if (land_miss)   cause_c = CAUSE_NO_LAND;
        else if (bounds) cause_c = CAUSE_BOUNDS;
        else if (mism)   cause_c = CAUSE_MISMATCH;
        else             cause_c = CAUSE_NONE;
    end

    assign trip        = active && (cause_c != CAUSE_NONE);
    assign commit      = active && !trip;
    assign stk_push_o  = commit && dec_i.push && !stk_full_i;
    assign stk_pop_o   = commit && dec_i.pop && !stk_empty_i;
    assign stk_flush_o = clear_i;

    // Next-state logic: transitions arm, settle, trip, clear
    always_comb begin
        state_n = state;
        unique case (state)
            ST_MONITOR, ST_ARMED: begin
                if (clear_i)     state_n = ST_MONITOR;
                else if (trip)   state_n = ST_HALTED;
                else if (active) state_n = dec_i.indirect ? ST_ARMED : ST_MONITOR;
            end
            ST_HALTED: begin
                if (clear_i)     state_n = ST_MONITOR;
            end
            default:             state_n = ST_MONITOR;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_MONITOR;
        else        state <= state_n;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_o <= 1'b0;
            cause_o <= CAUSE_NONE;
        end else begin
            fault_o <= trip;
            cause_o <= trip ? cause_c : CAUSE_NONE;
        end
    end

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    // R6
    halted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |=> !fault_o);

    // R2
    cause_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (cause_o != CAUSE_NONE));

    // R3
    landing_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && ev_valid_i && !clear_i && land_en_i && !dec_i.marker)
        |=> (fault_o && cause_o == CAUSE_NO_LAND));

    // R11
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid_i && !clear_i) |=> $stable(state));

endmodule

// File: rtl/cfi_monitor.sv
module cfi_monitor
    import cfi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ev_valid_i,
    input  logic [2:0]        ev_class_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic              ev_landing_i,
    input  logic              ret_chk_en_i,
    input  logic              land_chk_en_i,
    output logic              fault_o,
    output logic [1:0]        fault_cause_o
);

    ev_dec_t           dec;
    logic              stk_push, stk_pop, stk_flush;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty, stk_full;

    cfi_event_decode u_decode (
        .ev_class_i   (ev_class_i),
        .ev_landing_i (ev_landing_i),
        .dec_o        (dec)
    );

    cfi_shadow_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (stk_flush),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_addr_i (ev_addr_i),
        .top_o       (stk_top),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    cfi_fault_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .ev_valid_i  (ev_valid_i),
        .dec_i       (dec),
        .ev_addr_i   (ev_addr_i),
        .ret_en_i    (ret_chk_en_i),
        .land_en_i   (land_chk_en_i),
        .stk_top_i   (stk_top),
        .stk_empty_i (stk_empty),
        .stk_full_i  (stk_full),
        .stk_push_o  (stk_push),
        .stk_pop_o   (stk_pop),
        .stk_flush_o (stk_flush),
        .fault_o     (fault_o),
        .cause_o     (fault_cause_o)
    );

endmodule

// File: tb/cfi_monitor_test.sv
`timescale 1ns/1ps
module cfi_monitor_test;

    localparam int AW    = 32;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          ev_valid = 1'b0;
    logic [2:0]    ev_class = 3'd0;
    logic [AW-1:0] ev_addr = '0;
    logic          ev_land = 1'b0;
    logic          ret_en = 1'b1;
    logic          land_en = 1'b1;
    logic          fault;
    logic [1:0]    cause;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    logic [AW-1:0] shadow [$];
    bit            m_armed = 1'b0;
    bit            m_halted = 1'b0;
    logic          exp_fault = 1'b0;
    logic [1:0]    exp_cause = 2'b00;

    always #2 clk = ~clk;

    cfi_monitor #(.ADDR_W(AW), .DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear),
        .ev_valid_i    (ev_valid),
        .ev_class_i    (ev_class),
        .ev_addr_i     (ev_addr),
        .ev_landing_i  (ev_land),
        .ret_chk_en_i  (ret_en),
        .land_chk_en_i (land_en),
        .fault_o       (fault),
        .fault_cause_o (cause)
    );

    // Behavioural reference, evaluated once per rising edge
    task automatic model_edge();
        bit push, pop, ind, lm, ov, un, mm;
        exp_fault = 1'b0;
        exp_cause = 2'b00;
        if (!rst_n) begin
            shadow.delete();
            m_armed  = 1'b0;
            m_halted = 1'b0;
        end else if (clear) begin
            shadow.delete();
            m_armed  = 1'b0;
            m_halted = 1'b0;
        end else if (!m_halted && ev_valid) begin
            push = (ev_class == 3'd1) || (ev_class == 3'd2);
            pop  = (ev_class == 3'd3);
            ind  = (ev_class == 3'd2) || (ev_class == 3'd4);
            lm   = m_armed && !ev_land && land_en;
            ov   = push && (shadow.size() == DEPTH) && ret_en;
            un   = pop && (shadow.size() == 0) && ret_en;
            mm   = pop && (shadow.size() != 0) && ret_en && (shadow[$] != ev_addr);
            if (lm)            exp_cause = 2'b10;
            else if (ov || un) exp_cause = 2'b11;
            else if (mm)       exp_cause = 2'b01;
            if (exp_cause != 2'b00) begin
                exp_fault = 1'b1;
                m_halted  = 1'b1;
                m_armed   = 1'b0;
            end else begin
                if (push && shadow.size() < DEPTH) shadow.push_back(ev_addr);
                if (pop && shadow.size() > 0) void'(shadow.pop_back());
                m_armed = ind;
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        tests++;
        if (fault !== exp_fault || cause !== exp_cause) begin
            fails++;
            $display("FAIL %s: fault/cause actual %b/%b expected %b/%b",
                     tag, fault, cause, exp_fault, exp_cause);
        end
    endtask

    task automatic ev(input logic [2:0] cls, input logic [AW-1:0] a,
                      input logic lnd, input string tag);
        clear = 1'b0; ev_valid = 1'b1; ev_class = cls; ev_addr = a; ev_land = lnd;
        step(tag);
    endtask

    task automatic idle(input string tag);
        clear = 1'b0; ev_valid = 1'b0; ev_land = 1'b0;
        step(tag);
    endtask

    task automatic do_clear(input string tag);
        clear = 1'b1; ev_valid = 1'b0;
        step(tag);
        clear = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R6: watchdog expired, actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R6: quiet after reset
        rst_n = 1'b0;
        repeat (3) step("R6 reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R6 reset");

        // R1: nested call/return in LIFO order
        ev(3'd1, 32'h1000, 0, "R1");
        ev(3'd1, 32'h2000, 0, "R1");
        ev(3'd7, 32'h0, 0, "R1 unused code");
        ev(3'd3, 32'h2000, 0, "R1");
        ev(3'd3, 32'h1000, 0, "R1");
        idle("R1");

        // R2 and R6: mismatch, single-cycle pulse, then ignored events
        ev(3'd1, 32'hA0, 0, "R2");
        ev(3'd3, 32'hB0, 0, "R2");
        idle("R6 pulse");
        ev(3'd3, 32'hC0, 0, "R6 ignored");
        ev(3'd4, 32'h0, 0, "R6 ignored");
        ev(3'd0, 32'h0, 0, "R6 ignored");
        do_clear("R7");

        // R3: missing and present landing markers
        ev(3'd4, 32'h0, 0, "R3");
        ev(3'd0, 32'h0, 0, "R3");
        do_clear("R7");
        ev(3'd2, 32'h300, 0, "R3");
        ev(3'd0, 32'h0, 1, "R3");
        ev(3'd3, 32'h300, 0, "R3");

        // R4: lone marker, and a direct call does not arm
        ev(3'd0, 32'h0, 1, "R4");
        ev(3'd1, 32'h400, 0, "R4");
        ev(3'd0, 32'h0, 0, "R4");
        ev(3'd3, 32'h400, 0, "R4");

        // R5: underflow, then overflow at exactly DEPTH
        ev(3'd3, 32'h55, 0, "R5 underflow");
        do_clear("R7");
        for (int i = 0; i < DEPTH; i++) ev(3'd1, 32'h800 + i, 0, "R5 fill");
        ev(3'd1, 32'h999, 0, "R5 overflow");
        do_clear("R7");

        // R7: clear empties the stack
        ev(3'd1, 32'h77, 0, "R7");
        do_clear("R7");
        ev(3'd3, 32'h77, 0, "R7 underflow after clear");
        do_clear("R7");

        // R8: return check disabled keeps stack consistent
        ret_en = 1'b0;
        ev(3'd3, 32'h1, 0, "R8");
        ev(3'd1, 32'hA, 0, "R8");
        ev(3'd3, 32'hF, 0, "R8");
        ret_en = 1'b1;
        ev(3'd1, 32'hB, 0, "R8");
        ev(3'd3, 32'hB, 0, "R8");
        ev(3'd3, 32'hB, 0, "R8 underflow after re-enable");
        do_clear("R7");

        // R9: landing check disabled
        land_en = 1'b0;
        ev(3'd4, 32'h0, 0, "R9");
        ev(3'd0, 32'h0, 0, "R9");
        land_en = 1'b1;

        // R10: landing miss outranks underflow
        ev(3'd4, 32'h0, 0, "R10");
        ev(3'd3, 32'h0, 0, "R10");
        do_clear("R7");

        // R11: arming survives bubbles
        ev(3'd4, 32'h0, 0, "R11");
        repeat (3) idle("R11");
        ev(3'd0, 32'h0, 0, "R11");
        do_clear("R7");
        ev(3'd2, 32'h600, 0, "R11");
        idle("R11");
        ev(3'd0, 32'h0, 1, "R11");

        // Mixed stream against the reference
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                do_clear("R7 mix");
            end else if (r < 10) begin
                idle("R11 mix");
            end else begin
                ret_en  = ($urandom_range(0, 19) != 0);
                land_en = ($urandom_range(0, 19) != 0);
                a = 32'($urandom_range(0, 15));
                r = $urandom_range(0, 9);
                if (r < 3) ev(3'd1, a, 0, "R1 mix");
                else if (r < 4) ev(3'd2, a, 0, "R3 mix");
                else if (r < 5) ev(3'd4, a, 0, "R3 mix");
                else if (r < 8) begin
                    if (shadow.size() > 0 && $urandom_range(0, 3) != 0) a = shadow[$];
                    ev(3'd3, a, m_armed && $urandom_range(0, 1) == 0, "R2 mix");
                end else ev(3'd0, a, $urandom_range(0, 1) == 0, "R4 mix");
            end
        end
        ret_en = 1'b1;
        land_en = 1'b1;
        idle("R6");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule